// File: doc/BRIEF.md
# Vectored Interrupt Controller With Memory-Mapped Registers

This block gathers up to 32 interrupt lines from peripherals and presents them to a processor as one request wire plus a small bank of 32-bit registers. Each line is fixed at elaboration as either edge-sensitive or level-sensitive. A line that fires sets its bit in a status word. The status word masked by an enable word forms the pending word. A vector register names the lowest-numbered pending line, which is also the most urgent one. Software reads the vector, services the line, acknowledges it, and reads the vector again until it returns all-ones.

Enable bits can be changed one at a time with no read-modify-write. One write-only location ORs a mask into the enable word, and a second write-only location clears the masked bits. The request output is gated by a two-bit master control word. Both of its bits must be set before any request reaches the processor.

The register port is word-addressed. A 3-bit word index selects the register, so a byte offset is four times the index. Reads are combinational from the index. A write takes effect at the clock edge on which the write strobe is high.

Top module: `irqc_top`

## Requirements
- R1: After reset the status, enable and master words read zero, the vector reads 0xFFFFFFFF and the request output is low.
- R2: An edge-sensitive line (a 1 in the EDGE_MASK bit for that line) sets its status bit on a 0-to-1 transition of the input. The bit stays set after the input falls. If the input stays high, the bit does not set again after it is acknowledged.
- R3: A level-sensitive line (a 0 in the EDGE_MASK bit) sets its status bit in every cycle its input is high. An acknowledge while the input is still high leaves the bit set. An acknowledge after the input has fallen clears the bit.
- R4: A write to word 2 (offset 0x08) replaces the enable word. A write to word 4 (0x10) ORs the data into it. A write to word 5 (0x14) clears the bits that are 1 in the data. Enable bits outside the written mask keep their value.
- R5: A write to word 3 (0x0C) clears the status bits that are 1 in the data and leaves the others unchanged. The value 0xFFFFFFFF clears every latched status bit.
- R6: Word 0 (0x00) reads the status word. Word 1 (0x04) reads the pending word, which is status AND enable.
- R7: Word 6 (0x18) reads the index of the lowest-numbered pending bit, zero-extended. It reads 0xFFFFFFFF when nothing is pending.
- R8: Word 7 (0x1C) holds the master word. Bit 0 is the global enable and bit 1 is the hardware-output enable. The request output goes high in the cycle after a clock edge at which both bits are set and any bit is pending. It is low otherwise.
- R9: Status, enable and pending bits at positions NUM_SRC and above always read zero. Writing ones to them has no effect.
- R10: Words 3, 4 and 5 are write-only and read zero. Master bits 31..2 read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_word | input | 3 | Word index of the register accessed |
| wr_en | input | 1 | Write strobe for the indexed register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data of the indexed register |
| irq_in | input | NUM_SRC | Peripheral interrupt lines |
| irq_out | output | 1 | Registered interrupt request to the processor |

## Verification
The hardest cases to reach from the ports are an acknowledge that lands while the line is still asserted. A level line must survive that acknowledge. An edge line must be cleared and must not set again without a fresh transition. The stimulus holds a line high across an acknowledge write and reads the status word both before and after the line is released. The latency of the request output is checked in the exact cycle after the master word becomes complete, and again in the cycle after pending drops.

// File: rtl/irqc_pkg.sv
// Shared definitions for the interrupt controller: register word indices
// and the vector value that signals "nothing pending".
package irqc_pkg;

    localparam int DATA_W = 32;
    localparam logic [DATA_W-1:0] VEC_NONE = '1;

    // Register word index; software byte offset is index times four.
    typedef enum logic [2:0] {
        RI_STATUS = 3'd0,
        RI_PEND   = 3'd1,
        RI_ENABLE = 3'd2,
        RI_ACK    = 3'd3,
        RI_SETEN  = 3'd4,
        RI_CLREN  = 3'd5,
        RI_VECTOR = 3'd6,
        RI_MASTER = 3'd7
    } reg_idx_e;

endpackage

// File: rtl/irqc_capture.sv
// Per-line request capture. Edge lines latch on a 0->1 transition of the
// input. Level lines set every cycle the input is high. A latched bit is
// cleared by ack_mask. A new set event in the same cycle wins over the
// clear. Assumes irq_in is already synchronous to clk.
module irqc_capture #(
    parameter int          NUM_SRC   = 32,
    parameter logic [31:0] EDGE_MASK = 32'hFFFF_FFFF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic [NUM_SRC-1:0] ack_mask,
    output logic [NUM_SRC-1:0] status_q
);

    logic [NUM_SRC-1:0] set_now;

    for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_line
        if (EDGE_MASK[gi]) begin : g_edge
            logic prev_q;
            // Remember last input sample to detect a rising transition.
            always_ff @(posedge clk) begin
                if (!rst_n) prev_q <= 1'b0;
                else        prev_q <= irq_in[gi];
            end
            assign set_now[gi] = irq_in[gi] & ~prev_q;

            AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                (status_q[gi] && !ack_mask[gi]) |=> status_q[gi]); // R2
        end else begin : g_level
            assign set_now[gi] = irq_in[gi];

            AST_LEVEL_SET: assert property (@(posedge clk) disable iff (!rst_n)
                irq_in[gi] |=> status_q[gi]); // R3
        end
    end

    // Status word: clear acknowledged bits, then merge new set events.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~ack_mask) | set_now;
    end

endmodule

// File: rtl/irqc_enable.sv
// Enable word with three update paths: full replace, OR-in and
// clear-masked. The top decodes at most one strobe per cycle.
module irqc_enable #(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we_full,
    input  logic               we_set,
    input  logic               we_clr,
    input  logic [NUM_SRC-1:0] wmask,
    output logic [NUM_SRC-1:0] en_q
);

    // Apply whichever enable update is strobed this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)       en_q <= '0;
        else if (we_full) en_q <= wmask;
        else if (we_set)  en_q <= en_q | wmask;
        else if (we_clr)  en_q <= en_q & ~wmask;
    end

    AST_SET_ORS: assert property (@(posedge clk) disable iff (!rst_n)
        we_set |=> ((en_q & $past(wmask)) == $past(wmask))); // R4
    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        we_clr |=> ((en_q & $past(wmask)) == '0)); // R4

endmodule

// File: rtl/irqc_vector.sv
// Fixed-priority encoder. It reports the lowest-numbered set bit of the
// pending word and a hit flag. Line 0 has the highest priority.
module irqc_vector #(
    parameter int NUM_SRC = 32,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0] pend,
    output logic               hit,
    output logic [IDX_W-1:0]   idx
);

    // Scan downward so the lowest set index is the last one assigned.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pend[i]) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/irqc_top.sv
// Interrupt controller top: register decode, master gating, read mux and
// the registered request output. Reads are combinational from reg_word.
// Assumes a single-word write per cycle with wr_en.
module irqc_top
    import irqc_pkg::*;
#(
    parameter int          NUM_SRC   = 32,
    parameter logic [31:0] EDGE_MASK = 32'hFFFF_FFFF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         reg_word,
    input  logic               wr_en,
    input  logic [31:0]        wr_data,
    output logic [31:0]        rd_data,
    input  logic [NUM_SRC-1:0] irq_in,
    output logic               irq_out
);

    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    reg_idx_e           sel;
    logic [NUM_SRC-1:0] wmask;
    logic [NUM_SRC-1:0] ack_mask;
    logic [NUM_SRC-1:0] status;
    logic [NUM_SRC-1:0] enable;
    logic [NUM_SRC-1:0] pend;
    logic [1:0]         master_q;
    logic               vec_hit;
    logic [IDX_W-1:0]   vec_idx;
    logic [31:0]        vec_word;
    logic               irq_q;
    logic               unused_wr_hi;

    assign sel          = reg_idx_e'(reg_word);
    assign wmask        = wr_data[NUM_SRC-1:0];
    assign unused_wr_hi = &{1'b0, wr_data};
    assign ack_mask     = (wr_en && sel == RI_ACK) ? wmask : '0;

    irqc_capture #(.NUM_SRC(NUM_SRC), .EDGE_MASK(EDGE_MASK)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_in   (irq_in),
        .ack_mask (ack_mask),
        .status_q (status)
    );

    irqc_enable #(.NUM_SRC(NUM_SRC)) u_enable (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_full (wr_en && sel == RI_ENABLE),
        .we_set  (wr_en && sel == RI_SETEN),
        .we_clr  (wr_en && sel == RI_CLREN),
        .wmask   (wmask),
        .en_q    (enable)
    );

    assign pend = status & enable;

    irqc_vector #(.NUM_SRC(NUM_SRC)) u_vector (
        .pend (pend),
        .hit  (vec_hit),
        .idx  (vec_idx)
    );

    assign vec_word = vec_hit ? 32'(vec_idx) : VEC_NONE;

    // Master word: global enable (bit 0) and output enable (bit 1).
    always_ff @(posedge clk) begin
        if (!rst_n)                           master_q <= 2'b00;
        else if (wr_en && sel == RI_MASTER)   master_q <= wr_data[1:0];
    end

    // Registered request: any pending bit, gated by both master bits.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= (&master_q) & (|pend);
    end
    assign irq_out = irq_q;

    // Read mux; write-only words return zero.
    always_comb begin
        unique case (sel)
            RI_STATUS: rd_data = 32'(status);
            RI_PEND:   rd_data = 32'(pend);
            RI_ENABLE: rd_data = 32'(enable);
            RI_VECTOR: rd_data = vec_word;
            RI_MASTER: rd_data = {30'd0, master_q};
            default:   rd_data = '0;
        endcase
    end

    logic [NUM_SRC-1:0] below_idx;
    assign below_idx = (NUM_SRC'(1) << vec_idx) - NUM_SRC'(1);

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> ($past(master_q) == 2'b11)); // R8
    AST_IRQ_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        ((master_q == 2'b11) && (pend != '0)) |=> irq_out); // R8
    AST_VEC_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        vec_hit |-> (pend[vec_idx] && ((pend & below_idx) == '0))); // R7
    AST_VEC_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == '0) |-> (rd_data == VEC_NONE || sel != RI_VECTOR)); // R7

endmodule

// File: tb/tb_irqc_top.sv
// Bench for irqc_top with 12 lines: lines 0-3 and 8-11 are edge-sensitive,
// lines 4-7 are level-sensitive.
module tb_irqc_top;

    localparam int          CLK_PERIOD = 10;
    localparam int          NSRC       = 12;
    localparam logic [31:0] EMASK      = 32'h0000_0F0F;
    localparam int          WDOG       = 20000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [2:0]      reg_word = '0;
    logic            wr_en = 1'b0;
    logic [31:0]     wr_data = '0;
    logic [31:0]     rd_data;
    logic [NSRC-1:0] irq_in = '0;
    logic            irq_out;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    irqc_top #(.NUM_SRC(NSRC), .EDGE_MASK(EMASK)) dut (
        .clk(clk), .rst_n(rst_n), .reg_word(reg_word), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .irq_in(irq_in), .irq_out(irq_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // {input pattern, enable word, expected vector}
    localparam logic [55:0] TAB [6] = '{
        {12'h001, 12'hFFF, 32'd0},
        {12'h0A0, 12'hFFF, 32'd5},
        {12'h0A0, 12'h080, 32'd7},
        {12'hC00, 12'hFFF, 32'd10},
        {12'hFFF, 12'h000, 32'hFFFF_FFFF},
        {12'h810, 12'h800, 32'd11}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] w, input logic [31:0] d);
        @(negedge clk);
        reg_word = w; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] w, output logic [31:0] d);
        reg_word = w;
        #1 d = rd_data;
    endtask

    task automatic pulse(input logic [NSRC-1:0] m);
        @(negedge clk); irq_in = irq_in | m;
        @(negedge clk); irq_in = irq_in & ~m;
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(3'd0, v); check("R1 status", v, 32'h0);
        rd(3'd2, v); check("R1 enable", v, 32'h0);
        rd(3'd7, v); check("R1 master", v, 32'h0);
        rd(3'd6, v); check("R1 vector", v, 32'hFFFF_FFFF);
        check("R1 irq_out", {31'd0, irq_out}, 32'h0);

        // Table walk: R2/R3 latch, R6 pending, R7 vector
        for (int k = 0; k < 6; k++) begin
            logic [11:0] pat, en;
            logic [31:0] evec;
            {pat, en, evec} = TAB[k];
            wr(3'd2, 32'(en));
            pulse(pat);
            @(negedge clk);
            rd(3'd0, v); check("R6 status word", v, 32'(pat));
            rd(3'd1, v); check("R6 pending word", v, 32'(pat & en));
            rd(3'd6, v); check("R7 vector", v, evec);
            wr(3'd3, 32'hFFFF_FFFF);
        end
        rd(3'd0, v); check("R5 all-ones ack clears", v, 32'h0);

        // R2 edge line held high across an acknowledge
        @(negedge clk); irq_in[0] = 1'b1;
        repeat (2) @(negedge clk);
        rd(3'd0, v); check("R2 edge latched", v, 32'h001);
        wr(3'd3, 32'h001);
        @(negedge clk);
        rd(3'd0, v); check("R2 no re-set while held", v, 32'h0);
        irq_in[0] = 1'b0;
        pulse(12'h002);
        repeat (3) @(negedge clk);
        rd(3'd0, v); check("R2 holds after input falls", v, 32'h002);

        // R5 partial acknowledge
        pulse(12'h101);
        wr(3'd3, 32'h003);
        rd(3'd0, v); check("R5 partial ack", v, 32'h100);
        wr(3'd3, 32'hFFFF_FFFF);

        // R3 level line acknowledged while high, then after falling
        @(negedge clk); irq_in[4] = 1'b1;
        wr(3'd3, 32'h010);
        @(negedge clk);
        rd(3'd0, v); check("R3 level survives ack", v, 32'h010);
        irq_in[4] = 1'b0;
        @(negedge clk);
        wr(3'd3, 32'h010);
        rd(3'd0, v); check("R3 ack after fall clears", v, 32'h0);

        // R4 enable update paths
        wr(3'd2, 32'h00F);
        wr(3'd4, 32'h030);
        rd(3'd2, v); check("R4 set-enable ORs", v, 32'h03F);
        wr(3'd5, 32'h005);
        rd(3'd2, v); check("R4 clear-enable masked", v, 32'h03A);

        // R9 unimplemented bits
        wr(3'd2, 32'hFFFF_FFFF);
        rd(3'd2, v); check("R9 enable high bits", v, 32'h0000_0FFF);
        wr(3'd4, 32'hFFFF_F000);
        rd(3'd2, v); check("R9 set high bits", v, 32'h0000_0FFF);

        // R10 write-only words read zero, master width
        rd(3'd3, v); check("R10 ack reads zero", v, 32'h0);
        rd(3'd4, v); check("R10 set reads zero", v, 32'h0);
        rd(3'd5, v); check("R10 clear reads zero", v, 32'h0);
        wr(3'd7, 32'hFFFF_FFFF);
        rd(3'd7, v); check("R10 master width", v, 32'h3);
        wr(3'd7, 32'h0);

        // R8 master gating and latency
        wr(3'd2, 32'h002);
        pulse(12'h002);
        wr(3'd7, 32'h1);
        @(negedge clk);
        check("R8 only global enable", {31'd0, irq_out}, 32'h0);
        wr(3'd7, 32'h2);
        @(negedge clk);
        check("R8 only output enable", {31'd0, irq_out}, 32'h0);
        wr(3'd7, 32'h3);
        check("R8 one-cycle latency", {31'd0, irq_out}, 32'h0);
        @(negedge clk);
        check("R8 request asserted", {31'd0, irq_out}, 32'h1);
        wr(3'd5, 32'h002);
        check("R8 still high one cycle", {31'd0, irq_out}, 32'h1);
        @(negedge clk);
        check("R8 drops after pending clears", {31'd0, irq_out}, 32'h0);
        rd(3'd6, v); check("R7 vector empty", v, 32'hFFFF_FFFF);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule